// File: doc/BRIEF.md
# Eight-bit Unsigned Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for an 8-bit datapath. It takes a 4-bit operation code and two unsigned 8-bit operands, `opA` and `opB`. It returns one 16-bit result in the same evaluation.

Byte-sized operations produce an 8-bit answer with the upper byte held at zero. These are add, subtract, AND, OR, XOR, left shift and right shift. Multiply returns the whole 16-bit product.

Divide packs two values into the one result word: the remainder goes in the upper byte and the quotient in the lower byte. A zero divisor does not stop anything. The unit returns an all-ones word and raises `divByZero` for as long as that input combination is present. A surrounding core that registers the result and decides how to react to the flag uses this block as its execute stage.

Top module: `alu8_top`

## Requirements
- R1: Code 0x1 gives (opA + opB) mod 256 in result[7:0] with result[15:8] = 0.
- R2: Code 0x2 gives (opA − opB) mod 256 in result[7:0] with result[15:8] = 0.
- R3: Code 0x3 gives the full unsigned 16-bit product opA × opB in result[15:0].
- R4: Code 0x4 with opB ≠ 0 gives the unsigned quotient opA / opB in result[7:0] and the remainder opA mod opB in result[15:8], with divByZero low.
- R5: Code 0x4 with opB = 0 gives result = 0xFFFF with divByZero high.
- R6: Codes 0x5, 0x6 and 0x7 give bitwise AND, OR and XOR of the operands in result[7:0] with result[15:8] = 0.
- R7: Code 0x8 gives opA shifted left by opB (zero fill, low 8 bits kept) in result[7:0]. Any opB of 8 or more gives zero. result[15:8] = 0.
- R8: Code 0x9 gives opA shifted right logically by opB in result[7:0]. Any opB of 8 or more gives zero. result[15:8] = 0.
- R9: Codes 0x0 and 0xA through 0xF give result = 0 and divByZero low.
- R10: divByZero is high only when the code is 0x4 and opB is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation select code |
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand, also the divisor and the shift count |
| result | output | 16 | Operation result; upper byte zero for byte-sized operations |
| divByZero | output | 1 | High while a divide sees a zero divisor |

## Verification
The bench sweeps all sixteen codes against operand values chosen to hit each edge: zero, one, seven, eight, nine, 0x80, 0xFF and an alternating pattern.

Several wrong designs show up at these values:
- A unit that uses the raw shift operator at a count of 8 or 9 gives the right answer by luck. The bench therefore also pushes a count of 0xFF and a left shift of 0x80 by one.
- A unit that sign-extends on the right shift returns ones in the high bits for 0x80.
- A subtract that borrows into the upper byte leaves that byte non-zero on 0 − 1.
- A divide with the two halves swapped, or with no guard for a zero divisor, gives a wrong packed word or a missing flag.
- A decode that lets the unused codes through gives a non-zero result or a stray flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_MUL  = 4'h3,
    OP_DIV  = 4'h4,
    OP_AND  = 4'h5,
    OP_OR   = 4'h6,
    OP_XOR  = 4'h7,
    OP_SHL  = 4'h8,
    OP_SHR  = 4'h9
  } aluOp_e;

  // one-hot strobes from decode to datapath
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selMul;
    logic selDiv;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selShl;
    logic selShr;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] opCode,
  output aluStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    case (opCode)
      OP_ADD: strobe.selAdd = 1'b1;
      OP_SUB: strobe.selSub = 1'b1;
      OP_MUL: strobe.selMul = 1'b1;
      OP_DIV: strobe.selDiv = 1'b1;
      OP_AND: strobe.selAnd = 1'b1;
      OP_OR:  strobe.selOr  = 1'b1;
      OP_XOR: strobe.selXor = 1'b1;
      OP_SHL: strobe.selShl = 1'b1;
      OP_SHR: strobe.selShr = 1'b1;
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t          strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [2*DATA_W-1:0] result,
  output logic                divByZero
);

  localparam int WIDE_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] SHIFT_LIMIT = DATA_W'(DATA_W);

  logic [DATA_W-1:0] sumVal, diffVal, andVal, orVal, xorVal, shlVal, shrVal;
  logic [DATA_W-1:0] quotVal, remVal;
  logic [WIDE_W-1:0] prodVal, divWord;
  logic              zeroDivisor, shiftOut;

  assign sumVal      = opA + opB;
  assign diffVal     = opA - opB;
  assign andVal      = opA & opB;
  assign orVal       = opA | opB;
  assign xorVal      = opA ^ opB;
  assign prodVal     = WIDE_W'(opA) * WIDE_W'(opB);
  assign zeroDivisor = (opB == '0);
  assign shiftOut    = (opB >= SHIFT_LIMIT);

  always_comb begin
    if (zeroDivisor) begin
      quotVal = '0;
      remVal  = '0;
    end else begin
      quotVal = opA / opB;
      remVal  = opA % opB;
    end
  end

  assign divWord = zeroDivisor ? {WIDE_W{1'b1}} : {remVal, quotVal};
  assign shlVal  = shiftOut ? '0 : (opA << opB);
  assign shrVal  = shiftOut ? '0 : (opA >> opB);

  always_comb begin
    result = ({WIDE_W{strobe.selAdd}} & WIDE_W'(sumVal))
           | ({WIDE_W{strobe.selSub}} & WIDE_W'(diffVal))
           | ({WIDE_W{strobe.selMul}} & prodVal)
           | ({WIDE_W{strobe.selDiv}} & divWord)
           | ({WIDE_W{strobe.selAnd}} & WIDE_W'(andVal))
           | ({WIDE_W{strobe.selOr}}  & WIDE_W'(orVal))
           | ({WIDE_W{strobe.selXor}} & WIDE_W'(xorVal))
           | ({WIDE_W{strobe.selShl}} & WIDE_W'(shlVal))
           | ({WIDE_W{strobe.selShr}} & WIDE_W'(shrVal));
  end

  assign divByZero = strobe.selDiv & zeroDivisor;

endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0]   opCode,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [2*DATA_W-1:0] result,
  output logic                divByZero
);

  aluStrobe_t strobe;

  alu8_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .divByZero (divByZero)
  );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input logic [CODE_W-1:0]   opCode,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [2*DATA_W-1:0] result,
  input logic                divByZero
);

  logic byteOp, unusedOp;
  logic [2*DATA_W-1:0] rebuilt;

  assign byteOp   = (opCode == 4'h1) || (opCode == 4'h2) ||
                    ((opCode >= 4'h5) && (opCode <= 4'h9));
  assign unusedOp = (opCode == 4'h0) || (opCode >= 4'hA);
  assign rebuilt  = (2*DATA_W)'(result[DATA_W-1:0]) * (2*DATA_W)'(opB)
                  + (2*DATA_W)'(result[2*DATA_W-1:DATA_W]);

  always_comb begin
    // R10
    flag_source_chk: assert (!divByZero || (opCode == 4'h4 && opB == '0));
    // R5
    zero_div_word_chk: assert (!divByZero || (&result));
    // R9
    unused_code_chk: assert (!unusedOp || (result == '0 && !divByZero));
    // R1
    byte_upper_clear_chk: assert (!byteOp || result[2*DATA_W-1:DATA_W] == '0);
    // R4
    div_identity_chk: assert (!(opCode == 4'h4 && opB != '0) ||
                              (rebuilt == (2*DATA_W)'(opA) &&
                               result[2*DATA_W-1:DATA_W] < opB));
  end

endmodule

bind alu8_top alu8_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .opCode    (opCode),
  .opA       (opA),
  .opB       (opB),
  .result    (result),
  .divByZero (divByZero)
);

// File: tb/sim_alu8_top.sv
module sim_alu8_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = '0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [15:0] result;
  logic        divByZero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  alu8_top u0 (
    .opCode    (opCode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .divByZero (divByZero)
  );

  function automatic int refResult(int op, int a, int b);
    case (op)
      1: return (a + b) % 256;
      2: return (a - b + 256) % 256;
      3: return a * b;
      4: return (b == 0) ? 65535 : (((a % b) * 256) + (a / b));
      5: return a & b;
      6: return a | b;
      7: return a ^ b;
      8: return (b >= 8) ? 0 : ((a << b) % 256);
      9: return (b >= 8) ? 0 : (a >> b);
      default: return 0;
    endcase
  endfunction

  function automatic string reqTag(int op, int b);
    case (op)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return (b == 0) ? "R5" : "R4";
      5, 6, 7: return "R6";
      8: return "R7";
      9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic runOne(int op, int a, int b);
    int expR;
    int expF;
    @(negedge clk);
    opCode = op[3:0];
    opA    = a[7:0];
    opB    = b[7:0];
    @(posedge clk);
    #2ns;
    expR = refResult(op, a, b);
    expF = (op == 4 && b == 0) ? 1 : 0;
    checks++;
    if (int'(result) != expR) begin
      errors++;
      $display("FAIL %s op=%0h a=%0h b=%0h result actual=%04h expected=%04h",
               reqTag(op, b), op, a, b, result, expR[15:0]);
    end
    checks++;
    if (int'(divByZero) != expF) begin
      errors++;
      $display("FAIL R10 op=%0h a=%0h b=%0h divByZero actual=%0d expected=%0d",
               op, a, b, divByZero, expF);
    end
  endtask

  initial begin : watchdog
    #(8ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int vals[8] = '{0, 1, 7, 8, 9, 8'h55, 8'h80, 8'hFF};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: code 0 with zero operands gives zero result (R9)
    #2ns;
    checks++;
    if (result != 16'h0 || divByZero) begin
      errors++;
      $display("FAIL R9 idle actual=%04h/%0d expected=0000/0", result, divByZero);
    end
    // directed corners
    runOne(1, 8'hFF, 8'h01);   // R1 wrap to zero
    runOne(2, 8'h00, 8'h01);   // R2 borrow stays in low byte
    runOne(3, 8'hFF, 8'hFF);   // R3 full product FE01
    runOne(4, 8'hFF, 8'h10);   // R4 q=0F r=0F
    runOne(4, 8'h05, 8'h07);   // R4 quotient zero, remainder A
    runOne(4, 8'h33, 8'h00);   // R5 zero divisor
    runOne(8, 8'h80, 8'h01);   // R7 bit shifted out
    runOne(8, 8'h01, 8'hFF);   // R7 huge count
    runOne(9, 8'h80, 8'h07);   // R8 logical fill
    runOne(9, 8'hFF, 8'h08);   // R8 count of eight
    runOne(15, 8'hFF, 8'h00);  // R9 unused code, zero B must not flag
    runOne(10, 8'h12, 8'h34); // R9
    // sweep every code against the edge values
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runOne(op, vals[i], vals[j]);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule